// File: doc/BRIEF.md
# Inter-Processor Doorbell Hub

This block lets any core of an N-core system raise a software interrupt on any other core. Every core owns a control word and a status word in a small register window. A sender writes its own control word with a generate flag, the index of the destination core and an interrupt number. The hub then raises the private interrupt line of the destination core, never a shared line. It also records the pending request, the sender's index and the interrupt number in the destination's status word.

The receiving core reads its status word to learn who called it and why. It then writes its own control word with the acknowledge flag set, which clears the record and drops its line. Each destination holds one request at a time. A request aimed at a busy destination is refused and leaves the earlier one intact. The sender is expected to poll the destination's status word and try again. Reads are combinational over a single read/write port.

Top module: `doorbell_hub`

## Requirements
- R1: After a synchronous active-low reset, every interrupt line is low and every control and status word reads zero.
- R2: A write of a control word with bit 30 (generate) set and bits [29:16] (destination) below NUM_CORES raises the interrupt line of the destination core on the next clock edge, not the line of the core that owns the control word. Other lines are unchanged. The word 0x40010000 targets core 1 with interrupt number 0.
- R3: The same write sets the destination's status word to bit 30 = 1, bits [29:16] = index of the core whose control word was written, bits [15:0] = the interrupt number taken from control bits [15:0]. Bit 31 of the status word reads 0.
- R4: A write of a core's own control word with bit 31 (acknowledge) set clears that core's status word to zero and drops its line on the next clock edge.
- R5: A generate aimed at a destination whose request is still pending is refused. The destination's status word and line keep the earlier request.
- R6: A generate whose destination field is NUM_CORES or above changes no line and no status word.
- R7: When one write carries both acknowledge and generate, the acknowledge is applied first and the generate is then judged against the cleared state. Aimed at the writer itself, the line stays high and the status word shows the new request. Aimed at another idle core, the writer's line drops and the other core's line rises.
- R8: Address bit 0 selects the control word (0) or the status word (1), and address bits [ADDR_W-1:1] select the core. A control word reads back the last value written to it. A write to a status word address, or to any address whose core index is NUM_CORES or above, changes nothing. A read of such a core index returns zero.
- R9: A control write with neither bit 31 nor bit 30 set updates only that control word. It leaves all lines and status words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Word address: bit 0 selects control/status, upper bits select the core |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| core_irq | output | NUM_CORES | One private interrupt line per core |

## Verification
Acknowledge and generate can land on the same destination in the same cycle. This happens when a core writes its own control word with both flags set and names itself as the destination. The bench provokes this against a pending request and against a second, idle core. It judges the result by whether the line stays high and whether the status word shows the new sender and number rather than the old ones or zero. Around this case the bench sweeps every sender and destination pair of a four-core configuration. It also tries refused requests to busy or out-of-range destinations and writes to unmapped addresses, with the expected register contents worked out arithmetically.

// File: rtl/dbell_pkg.sv
// Shared field layout for the doorbell hub.
// Assumes 32-bit register words; the bit positions are the contract with software.
package dbell_pkg;
    localparam int WORD_W = 32;
    localparam int ID_W   = 14;
    localparam int NUM_W  = 16;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ID_W-1:0]   core_id_t;
    typedef logic [NUM_W-1:0]  irq_num_t;

    // Control word: bit31 acknowledge, bit30 generate, [29:16] target, [15:0] number
    typedef struct packed {
        logic     ack;
        logic     gen;
        core_id_t dst;
        irq_num_t num;
    } ctrl_t;

    // Status word: bit31 reserved, bit30 pending, [29:16] sender, [15:0] number
    typedef struct packed {
        logic     rsvd;
        logic     pend;
        core_id_t src;
        irq_num_t num;
    } stat_t;
endpackage

// File: rtl/dbell_decode.sv
// Write decoder: turns one bus write into per-core control enables, acknowledge
// strobes and at most one generate strobe toward a destination slot.
// Assumes ADDR_W-1 bits are enough to index NUM_CORES cores.
module dbell_decode
    import dbell_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  word_t                wdata,
    output logic [NUM_CORES-1:0] ctrl_we,
    output logic [NUM_CORES-1:0] ack_vec,
    output logic [NUM_CORES-1:0] gen_vec,
    output core_id_t             src_id,
    output irq_num_t             num
);
    localparam int SEL_W = ADDR_W - 1;
    localparam logic [SEL_W-1:0] SEL_LIMIT = SEL_W'(NUM_CORES);
    localparam core_id_t         DST_LIMIT = ID_W'(NUM_CORES);

    logic [SEL_W-1:0] sel;
    ctrl_t            cw;
    logic             hit;
    logic             dst_ok;

    assign sel    = addr[ADDR_W-1:1];
    assign cw     = ctrl_t'(wdata);
    assign hit    = wr && !addr[0] && (sel < SEL_LIMIT);
    assign dst_ok = cw.dst < DST_LIMIT;
    assign src_id = ID_W'(sel);
    assign num    = cw.num;

    // Fan the single write out to the owning slot and the named destination.
    always_comb begin
        for (int i = 0; i < NUM_CORES; i++) begin
            ctrl_we[i] = hit && (sel == SEL_W'(i));
            ack_vec[i] = ctrl_we[i] && cw.ack;
            gen_vec[i] = hit && cw.gen && dst_ok && (cw.dst == ID_W'(i));
        end
    end
endmodule

// File: rtl/dbell_slot.sv
// Per-core slot: the core's control word plus the single pending request aimed
// at it. Acknowledge is applied before generate within one cycle.
// Assumes gen and ack arrive already decoded for this core.
module dbell_slot
    import dbell_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctrl_we,
    input  word_t    wdata,
    input  logic     ack,
    input  logic     gen,
    input  core_id_t src_id,
    input  irq_num_t num,
    output word_t    ctrl_word,
    output word_t    stat_word,
    output logic     irq
);
    word_t ctrl_q;
    stat_t stat_q;
    stat_t stat_d;

    // Hold the last control word written by the owning core.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= wdata;
    end

    // Next request state: clear on acknowledge, then latch if now idle.
    always_comb begin
        stat_d = stat_q;
        if (ack) stat_d = '0;
        if (gen && !stat_d.pend) begin
            stat_d.pend = 1'b1;
            stat_d.src  = src_id;
            stat_d.num  = num;
        end
    end

    // Register the request state.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign ctrl_word = ctrl_q;
    assign stat_word = word_t'(stat_q);
    assign irq       = stat_q.pend;

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !gen) |=> (!irq && stat_word == '0));

    assert_latch_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gen && (ack || !irq)) |=> (irq && stat_q.src == $past(src_id) && stat_q.num == $past(num)));

    assert_busy_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gen && !ack && irq) |=> $stable(stat_word));

    assert_same_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gen && ack) |=> irq);

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen && !ack) |=> $stable(stat_word));
endmodule

// File: rtl/dbell_readmux.sv
// Combinational read port over all control and status words.
// Assumes addresses whose core index is out of range read as zero.
module dbell_readmux
    import dbell_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  word_t             ctrl_arr [NUM_CORES],
    input  word_t             stat_arr [NUM_CORES],
    output word_t             rdata
);
    localparam int SEL_W = ADDR_W - 1;

    logic [SEL_W-1:0] sel;
    assign sel = addr[ADDR_W-1:1];

    // Select the addressed word, zero when no core matches.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (sel == SEL_W'(i)) rdata = addr[0] ? stat_arr[i] : ctrl_arr[i];
        end
    end
endmodule

// File: rtl/doorbell_hub.sv
// Inter-processor doorbell hub: per-core control/status words and one private
// interrupt line per core. Assumes one bus write per cycle and a synchronous
// active-low reset.
module doorbell_hub
    import dbell_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_CORES-1:0] core_irq
);
    localparam int SEL_W = ADDR_W - 1;

    logic [NUM_CORES-1:0] ctrl_we;
    logic [NUM_CORES-1:0] ack_vec;
    logic [NUM_CORES-1:0] gen_vec;
    core_id_t             src_id;
    irq_num_t             num;
    word_t                ctrl_arr [NUM_CORES];
    word_t                stat_arr [NUM_CORES];

    dbell_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_decode (
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .ctrl_we (ctrl_we),
        .ack_vec (ack_vec),
        .gen_vec (gen_vec),
        .src_id  (src_id),
        .num     (num)
    );

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
        dbell_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl_we   (ctrl_we[g]),
            .wdata     (bus_wdata),
            .ack       (ack_vec[g]),
            .gen       (gen_vec[g]),
            .src_id    (src_id),
            .num       (num),
            .ctrl_word (ctrl_arr[g]),
            .stat_word (stat_arr[g]),
            .irq       (core_irq[g])
        );
    end

    dbell_readmux #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_rmux (
        .addr     (bus_addr),
        .ctrl_arr (ctrl_arr),
        .stat_arr (stat_arr),
        .rdata    (bus_rdata)
    );

    // Bus-level view used only by the checks below.
    ctrl_t                chk_cw;
    logic                 chk_ctrl_wr;
    logic [NUM_CORES-1:0] chk_dst_mask;
    assign chk_cw      = ctrl_t'(bus_wdata);
    assign chk_ctrl_wr = bus_wr && !bus_addr[0] && (bus_addr[ADDR_W-1:1] < SEL_W'(NUM_CORES));
    assign chk_dst_mask = (chk_cw.dst < ID_W'(NUM_CORES)) ? (NUM_CORES'(1) << chk_cw.dst) : '0;

    assert_target_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_ctrl_wr && chk_cw.gen && !chk_cw.ack && chk_dst_mask != '0 && (core_irq & chk_dst_mask) == '0)
        |=> core_irq == ($past(core_irq) | $past(chk_dst_mask)));

    assert_bad_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_ctrl_wr && chk_cw.gen && !chk_cw.ack && chk_dst_mask == '0) |=> $stable(core_irq));

    assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !chk_ctrl_wr) |=> $stable(core_irq));
endmodule

// File: tb/doorbell_hub_bench.sv
`timescale 1ns/1ps
module doorbell_hub_bench;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] core_irq;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [31:0] m_ctrl [N];
    logic        m_pend [N];
    logic [13:0] m_src  [N];
    logic [15:0] m_num  [N];

    always #2 clk = ~clk;

    doorbell_hub #(.NUM_CORES(N), .ADDR_W(8)) u_doorbell_hub (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_irq(core_irq)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected-state update computed from the requirement text.
    function automatic void model(input logic [7:0] a, input logic [31:0] d);
        int idx = int'(a >> 1);
        int dd  = int'(d[29:16]);
        if (a[0] == 1'b0 && idx < N) begin
            m_ctrl[idx] = d;
            if (d[31]) begin
                m_pend[idx] = 1'b0; m_src[idx] = '0; m_num[idx] = '0;
            end
            if (d[30] && dd < N && !m_pend[dd]) begin
                m_pend[dd] = 1'b1; m_src[dd] = 14'(idx); m_num[dd] = d[15:0];
            end
        end
    endfunction

    task automatic wr_raw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model(a, d);
    endtask

    task automatic wr_ctrl(input int core, input logic [31:0] d);
        wr_raw(8'(core * 2), d);
    endtask

    function automatic logic [31:0] mk(input bit ack, input bit gen, input int dst, input int nm);
        return {ack, gen, 14'(dst), 16'(nm)};
    endfunction

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic check_all(input string req);
        logic [31:0] v;
        for (int i = 0; i < N; i++) begin
            check(req, $sformatf("line %0d", i), 32'(core_irq[i]), 32'(m_pend[i]));
            rd(8'(i * 2 + 1), v);
            check(req, $sformatf("status %0d", i), v, {1'b0, m_pend[i], m_src[i], m_num[i]});
            rd(8'(i * 2), v);
            check(req, $sformatf("control %0d", i), v, m_ctrl[i]);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < N; i++) begin
            m_ctrl[i] = '0; m_pend[i] = 1'b0; m_src[i] = '0; m_num[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2 R3 R4: every sender/destination pair, then acknowledge.
        for (int s = 0; s < N; s++) begin
            for (int d = 0; d < N; d++) begin
                wr_ctrl(s, mk(0, 1, d, s * 16 + d + 5));
                check_all("R2 R3");
                wr_ctrl(d, mk(1, 0, 0, 0));
                check_all("R4");
            end
        end

        // R2: literal example word targets core 1.
        wr_ctrl(0, 32'h4001_0000);
        check_all("R2");
        wr_ctrl(1, 32'h8000_0000);
        check_all("R4");

        // R5: second sender refused while destination busy.
        wr_ctrl(0, mk(0, 1, 2, 16'h11));
        wr_ctrl(1, mk(0, 1, 2, 16'h22));
        check_all("R5");
        wr_ctrl(3, mk(0, 1, 2, 16'h33));
        check_all("R5");

        // R9: plain write leaves requests alone.
        wr_ctrl(3, 32'h0012_3456);
        check_all("R9");

        // R6: destinations at or above the core count.
        wr_ctrl(1, mk(0, 1, 4, 1));
        check_all("R6");
        wr_ctrl(1, mk(0, 1, 5, 2));
        check_all("R6");
        wr_ctrl(0, mk(0, 1, 16'h3FFF, 3));
        check_all("R6");

        // R7: acknowledge and generate to self in one write.
        wr_ctrl(2, mk(1, 1, 2, 16'h99));
        check_all("R7");
        check("R7", "line 2 held", 32'(core_irq[2]), 32'd1);
        // R7: acknowledge self and generate to an idle core.
        wr_ctrl(2, mk(1, 1, 0, 16'h44));
        check_all("R7");
        check("R7", "line 2 dropped", 32'(core_irq[2]), 32'd0);
        check("R7", "line 0 raised", 32'(core_irq[0]), 32'd1);

        // R8: unmapped and status addresses.
        wr_raw(8'h01, mk(0, 1, 3, 7));
        check_all("R8");
        for (int k = N; k < 8; k++) begin
            wr_raw(8'(k * 2), mk(0, 1, 1, k));
            check_all("R8");
        end
        wr_raw(8'hFE, mk(1, 1, 3, 8));
        check_all("R8");
        rd(8'h09, v);
        check("R8", "unmapped status read", v, 32'h0);
        rd(8'hFE, v);
        check("R8", "unmapped control read", v, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule